// File: doc/BRIEF.md
# Privilege-Gated Counter Register Block

This block holds the read-only event counters that a small processor core exposes to software, together with the controls that decide which privilege level may read them. There are 32 counter slots. Slot 0 counts clock cycles, slot 1 returns a wall-clock value supplied from outside, and slot 2 counts retired instructions. Slots 3 to 31 are placeholders for event counters, and each of them returns the cycle count.

Reads are combinational. A slot index goes in and the value comes out in the same cycle. Before the value reaches the output it passes a permission filter. That filter depends on the current privilege level and on two 32-bit enable masks, one granted by machine mode and one granted by supervisor mode. A denied read returns zero and raises no trap.

A single write port, decoded by a select code, updates the two masks and the privilege level. Writes that target a counter slot are dropped without any effect.

Top module: `ctr_csr_gate`

## Requirements
- R1: After reset the privilege level is machine (code 3), both enable masks hold 0x7 (slots 0, 1 and 2 enabled), and the cycle and retired-instruction counts are zero.
- R2: The cycle count is 64 bits wide and increases by one on every clock edge at which reset is low. A permitted read of slot 0 returns it.
- R3: The retired-instruction count is 64 bits wide and increases by one on each clock edge at which `retire_i` is high. A permitted read of slot 2 returns it.
- R4: A permitted read of slot 1 returns the current value of `time_i`.
- R5: A permitted read of any slot from 3 to 31 returns the cycle count.
- R6: In machine privilege (code 3), every read of slots 0 to 31 is permitted, whatever the masks hold.
- R7: In supervisor privilege (code 1), a read of slot n is permitted only when bit n of the machine-granted mask is 1.
- R8: In user privilege (code 0), a read of slot n is permitted only when bit n of the supervisor-granted mask is 1.
- R9: A denied read returns zero on `rd_data_o` and leaves every count unchanged, so a later permitted read shows counting that never stopped.
- R10: The reserved privilege code 2 denies reads of every slot.
- R11: A read index of 32 to 63 drives `rd_illegal_o` high and returns zero. Indices 0 to 31 keep `rd_illegal_o` low.
- R12: When `wr_en_i` is high, the write takes effect at the next clock edge. Select 32 loads the machine-granted mask from `wr_data_i`, select 33 loads the supervisor-granted mask, and select 34 loads the privilege level from `wr_data_i[1:0]`. Selects 0 to 31 (the counter slots) and 35 to 63 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| retire_i | input | 1 | One instruction retired this cycle |
| time_i | input | 64 | External wall-clock value |
| wr_en_i | input | 1 | Write strobe |
| wr_sel_i | input | 6 | Write select code |
| wr_data_i | input | 32 | Write data |
| rd_idx_i | input | 6 | Counter slot index to read |
| rd_data_o | output | 64 | Read value, or zero if denied or illegal |
| rd_illegal_o | output | 1 | Read index outside 0 to 31 |

## Verification
All 32 slot indices are swept under each privilege level: machine with both masks cleared, supervisor with a sparse machine-granted mask, user with a supervisor-granted mask that has only the time bit and the top bit set, and the reserved level. These sweeps show whether the gate uses the wrong mask, ignores the level, or misses a bit position. The retire strobe toggles in an irregular pattern, and the wall-clock input changes on every cycle. Together these separate slot 0, slot 1, slot 2 and the mirrored slots from each other. Writes aimed at counter slots and at unused selects are interleaved with reads, out-of-range indices are probed, and counts are read both before and after a long denied stretch.

// File: rtl/ctrgate_pkg.sv
package ctrgate_pkg;

    localparam int NSLOT  = 32;
    localparam int SLOT_W = $clog2(NSLOT);
    localparam int SEL_W  = SLOT_W + 1;

    localparam int SLOT_CYCLE   = 0;
    localparam int SLOT_TIME    = 1;
    localparam int SLOT_INSTRET = 2;

    typedef logic [NSLOT-1:0] en_mask_t;

    typedef enum logic [1:0] {
        PRIV_U   = 2'd0,
        PRIV_S   = 2'd1,
        PRIV_RSV = 2'd2,
        PRIV_M   = 2'd3
    } priv_e;

    typedef struct packed {
        priv_e    lvl;
        en_mask_t m_en;
        en_mask_t s_en;
    } gate_t;

    localparam en_mask_t EN_RESET = en_mask_t'(7);

    localparam logic [SEL_W-1:0] SEL_MEN  = SEL_W'(NSLOT);
    localparam logic [SEL_W-1:0] SEL_SEN  = SEL_W'(NSLOT + 1);
    localparam logic [SEL_W-1:0] SEL_PRIV = SEL_W'(NSLOT + 2);

    // Machine reads everything; supervisor is limited by the machine-granted
    // mask; user is limited by the supervisor-granted mask.
    function automatic logic gate_pass(gate_t g, logic [SLOT_W-1:0] s);
        logic ok;
        case (g.lvl)
            PRIV_M:  ok = 1'b1;
            PRIV_S:  ok = g.m_en[s];
            PRIV_U:  ok = g.s_en[s];
            default: ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/ctrgate_counters.sv
module ctrgate_counters #(
    parameter int CTR_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             retire_i,
    output logic [CTR_W-1:0] cycle_o,
    output logic [CTR_W-1:0] instret_o
);

    logic [CTR_W-1:0] cycle_q;
    logic [CTR_W-1:0] instret_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cycle_q <= '0;
        end else begin
            cycle_q <= cycle_q + CTR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            instret_q <= '0;
        end else if (retire_i) begin
            instret_q <= instret_q + CTR_W'(1);
        end
    end

    assign cycle_o   = cycle_q;
    assign instret_o = instret_q;

endmodule

// File: rtl/ctrgate_state.sv
module ctrgate_state
    import ctrgate_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en_i,
    input  logic [SEL_W-1:0] wr_sel_i,
    input  en_mask_t         wr_data_i,
    output gate_t            gate_o
);

    gate_t gate_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_q.lvl  <= PRIV_M;
            gate_q.m_en <= EN_RESET;
            gate_q.s_en <= EN_RESET;
        end else if (wr_en_i) begin
            case (wr_sel_i)
                SEL_MEN:  gate_q.m_en <= wr_data_i;
                SEL_SEN:  gate_q.s_en <= wr_data_i;
                SEL_PRIV: gate_q.lvl  <= priv_e'(wr_data_i[1:0]);
                default:  ; // counter slots and unused codes are dropped
            endcase
        end
    end

    assign gate_o = gate_q;

endmodule

// File: rtl/ctrgate_perm.sv
module ctrgate_perm
    import ctrgate_pkg::*;
(
    input  gate_t            gate_i,
    input  logic [SEL_W-1:0] idx_i,
    output logic             allow_o,
    output logic             illegal_o
);

    logic [SLOT_W-1:0] slot;

    assign slot      = idx_i[SLOT_W-1:0];
    assign illegal_o = (idx_i >= SEL_W'(NSLOT));
    assign allow_o   = !illegal_o && gate_pass(gate_i, slot);

endmodule

// File: rtl/ctr_csr_gate.sv
module ctr_csr_gate
    import ctrgate_pkg::*;
#(
    parameter int CTR_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             retire_i,
    input  logic [CTR_W-1:0] time_i,
    input  logic             wr_en_i,
    input  logic [SEL_W-1:0] wr_sel_i,
    input  logic [NSLOT-1:0] wr_data_i,
    input  logic [SEL_W-1:0] rd_idx_i,
    output logic [CTR_W-1:0] rd_data_o,
    output logic             rd_illegal_o
);

    logic [CTR_W-1:0] cycle_w;
    logic [CTR_W-1:0] instret_w;
    gate_t            gate_w;
    logic             allow_w;
    logic [CTR_W-1:0] slot_val [NSLOT];
    logic [1:0]       lvl_w;
    en_mask_t         m_en_w;
    en_mask_t         s_en_w;

    ctrgate_counters #(.CTR_W(CTR_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .retire_i  (retire_i),
        .cycle_o   (cycle_w),
        .instret_o (instret_w)
    );

    ctrgate_state u_state (
        .clk       (clk),
        .rst       (rst),
        .wr_en_i   (wr_en_i),
        .wr_sel_i  (wr_sel_i),
        .wr_data_i (wr_data_i),
        .gate_o    (gate_w)
    );

    ctrgate_perm u_perm (
        .gate_i    (gate_w),
        .idx_i     (rd_idx_i),
        .allow_o   (allow_w),
        .illegal_o (rd_illegal_o)
    );

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        if (g == SLOT_TIME) begin : g_time
            assign slot_val[g] = time_i;
        end else if (g == SLOT_INSTRET) begin : g_inst
            assign slot_val[g] = instret_w;
        end else begin : g_cyc
            assign slot_val[g] = cycle_w;
        end
    end

    assign rd_data_o = allow_w ? slot_val[rd_idx_i[SLOT_W-1:0]] : '0;

    assign lvl_w  = gate_w.lvl;
    assign m_en_w = gate_w.m_en;
    assign s_en_w = gate_w.s_en;

endmodule

// File: rtl/ctrgate_chk.sv
module ctrgate_chk
    import ctrgate_pkg::*;
#(
    parameter int CTR_W = 64
) (
    input logic             clk,
    input logic             rst,
    input logic             retire_i,
    input logic [CTR_W-1:0] time_i,
    input logic             wr_en_i,
    input logic [SEL_W-1:0] wr_sel_i,
    input logic [SEL_W-1:0] rd_idx_i,
    input logic [CTR_W-1:0] rd_data_o,
    input logic             rd_illegal_o,
    input logic [CTR_W-1:0] cycle,
    input logic [CTR_W-1:0] instret,
    input logic [1:0]       lvl,
    input logic [NSLOT-1:0] m_en,
    input logic [NSLOT-1:0] s_en,
    input logic             allow
);

    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (lvl == 2'd3 && m_en == NSLOT'(7) && s_en == NSLOT'(7)
                        && cycle == '0 && instret == '0));

    a_r2_cycle_step: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> cycle == $past(cycle) + CTR_W'(1));

    a_r3_instret_step: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(retire_i)) |-> instret == $past(instret) + CTR_W'(1));

    a_r3_instret_hold: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(retire_i)) |-> $stable(instret));

    a_r4_time_slot: assert property (@(posedge clk) disable iff (rst)
        (lvl == 2'd3 && rd_idx_i == SEL_W'(1)) |-> rd_data_o == time_i);

    a_r5_mirror_cycle: assert property (@(posedge clk) disable iff (rst)
        (lvl == 2'd3 && rd_idx_i >= SEL_W'(3) && rd_idx_i < SEL_W'(NSLOT))
        |-> rd_data_o == cycle);

    a_r6_machine_open: assert property (@(posedge clk) disable iff (rst)
        (lvl == 2'd3 && rd_idx_i < SEL_W'(NSLOT)) |-> allow);

    a_r9_denied_zero: assert property (@(posedge clk) disable iff (rst)
        !allow |-> rd_data_o == '0);

    a_r10_reserved_closed: assert property (@(posedge clk) disable iff (rst)
        lvl == 2'd2 |-> (!allow && rd_data_o == '0));

    a_r11_out_of_range: assert property (@(posedge clk) disable iff (rst)
        rd_idx_i >= SEL_W'(NSLOT) |-> (rd_illegal_o && rd_data_o == '0));

    a_r12_counter_write_dropped: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && wr_sel_i < SEL_W'(NSLOT)) |=>
        ($stable(lvl) && $stable(m_en) && $stable(s_en)));

endmodule

bind ctr_csr_gate ctrgate_chk #(.CTR_W(CTR_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .retire_i     (retire_i),
    .time_i       (time_i),
    .wr_en_i      (wr_en_i),
    .wr_sel_i     (wr_sel_i),
    .rd_idx_i     (rd_idx_i),
    .rd_data_o    (rd_data_o),
    .rd_illegal_o (rd_illegal_o),
    .cycle        (cycle_w),
    .instret      (instret_w),
    .lvl          (lvl_w),
    .m_en         (m_en_w),
    .s_en         (s_en_w),
    .allow        (allow_w)
);

// File: tb/test_ctr_csr_gate.sv
module test_ctr_csr_gate;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        retire_i = 1'b0;
    logic [63:0] time_i = '0;
    logic        wr_en_i = 1'b0;
    logic [5:0]  wr_sel_i = '0;
    logic [31:0] wr_data_i = '0;
    logic [5:0]  rd_idx_i = '0;
    logic [63:0] rd_data_o;
    logic        rd_illegal_o;

    int n_chk = 0;
    int n_err = 0;

    // Reference state, advanced at each rising edge from the requirements.
    logic [63:0] m_cyc, m_inst;
    logic [1:0]  m_priv;
    logic [31:0] m_men, m_sen;

    ctr_csr_gate i_ctr_csr_gate (
        .clk          (clk),
        .rst          (rst),
        .retire_i     (retire_i),
        .time_i       (time_i),
        .wr_en_i      (wr_en_i),
        .wr_sel_i     (wr_sel_i),
        .wr_data_i    (wr_data_i),
        .rd_idx_i     (rd_idx_i),
        .rd_data_o    (rd_data_o),
        .rd_illegal_o (rd_illegal_o)
    );

    always #(CLK_P/2) clk = ~clk;

    always @(posedge clk) begin
        if (rst) begin
            m_cyc = '0; m_inst = '0; m_priv = 2'd3;
            m_men = 32'h7; m_sen = 32'h7;
        end else begin
            m_cyc = m_cyc + 1;
            if (retire_i) m_inst = m_inst + 1;
            if (wr_en_i) begin
                if (wr_sel_i == 6'd32) m_men = wr_data_i;
                else if (wr_sel_i == 6'd33) m_sen = wr_data_i;
                else if (wr_sel_i == 6'd34) m_priv = wr_data_i[1:0];
            end
        end
    end

    task automatic check(input string tag);
        logic [63:0] exp_d;
        logic        exp_ill;
        logic        ok;
        exp_ill = (rd_idx_i > 6'd31);
        if (exp_ill) ok = 1'b0;
        else if (m_priv == 2'd3) ok = 1'b1;
        else if (m_priv == 2'd1) ok = m_men[rd_idx_i[4:0]];
        else if (m_priv == 2'd0) ok = m_sen[rd_idx_i[4:0]];
        else ok = 1'b0;
        if (!ok) exp_d = '0;
        else if (rd_idx_i == 6'd1) exp_d = time_i;
        else if (rd_idx_i == 6'd2) exp_d = m_inst;
        else exp_d = m_cyc;
        n_chk++;
        if (rd_data_o !== exp_d || rd_illegal_o !== exp_ill) begin
            n_err++;
            $display("FAIL %s: idx=%0d data=%h ill=%b expected data=%h ill=%b",
                     tag, rd_idx_i, rd_data_o, rd_illegal_o, exp_d, exp_ill);
        end
    endtask

    task automatic step(input logic ret, input logic we, input logic [5:0] ws,
                        input logic [31:0] wd, input logic [5:0] ri, input string tag);
        @(negedge clk);
        retire_i  = ret;
        wr_en_i   = we;
        wr_sel_i  = ws;
        wr_data_i = wd;
        rd_idx_i  = ri;
        time_i    = 64'h0123_4567_0000_0000 + 64'(n_chk) * 64'd977;
        #1;
        check(tag);
    endtask

    task automatic wr(input logic [5:0] ws, input logic [31:0] wd, input string tag);
        step(1'b0, 1'b1, ws, wd, 6'd0, tag);
    endtask

    initial begin
        #(CLK_P * 50000);
        n_err++;
        $display("FAIL watchdog: run still busy, expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        // R1: reset state
        step(0, 0, 0, 0, 6'd0, "R1");
        step(1, 0, 0, 0, 6'd2, "R1");
        @(negedge clk);
        rst = 1'b0;
        step(0, 0, 0, 0, 6'd0, "R1");
        // R2: cycle count
        for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 6'd0, "R2");
        // R3: retire pattern
        for (int i = 0; i < 10; i++) step((i % 3) != 0, 0, 0, 0, 6'd2, "R3");
        // R4: wall clock
        for (int i = 0; i < 4; i++) step(1, 0, 0, 0, 6'd1, "R4");
        // R5: mirrored slots
        for (int i = 3; i < 32; i++) step(i[0], 0, 0, 0, 6'(i), "R5");
        // R11: out-of-range indices
        step(0, 0, 0, 0, 6'd32, "R11");
        step(1, 0, 0, 0, 6'd47, "R11");
        step(0, 0, 0, 0, 6'd63, "R11");
        step(0, 0, 0, 0, 6'd31, "R11");
        // R1: reset masks seen from supervisor level
        wr(6'd34, 32'd1, "R1");
        for (int i = 0; i < 5; i++) step(1, 0, 0, 0, 6'(i), "R1");
        // R12: writes to counters and unused codes dropped
        step(1, 1, 6'd0, 32'hFFFF_FFFF, 6'd0, "R12");
        step(0, 1, 6'd2, 32'hFFFF_FFFF, 6'd2, "R12");
        step(1, 1, 6'd31, 32'h0, 6'd0, "R12");
        step(0, 1, 6'd40, 32'h3, 6'd2, "R12");
        step(0, 1, 6'd63, 32'h0, 6'd3, "R12");
        for (int i = 0; i < 4; i++) step(i[0], 0, 0, 0, 6'(i), "R12");
        // R6: machine ignores masks
        wr(6'd34, 32'd3, "R6");
        wr(6'd32, 32'd0, "R6");
        wr(6'd33, 32'd0, "R6");
        for (int i = 0; i < 32; i++) step(i[1], 0, 0, 0, 6'(i), "R6");
        // R7: supervisor uses machine-granted mask
        wr(6'd32, 32'h0000_0005, "R7");
        wr(6'd34, 32'd1, "R7");
        for (int i = 0; i < 32; i++) step(i[0], 0, 0, 0, 6'(i), "R7");
        // R8: user uses supervisor-granted mask
        wr(6'd33, 32'h8000_0002, "R8");
        wr(6'd34, 32'd0, "R8");
        for (int i = 0; i < 32; i++) step(i[2], 0, 0, 0, 6'(i), "R8");
        // R10: reserved level denies all
        wr(6'd34, 32'd2, "R10");
        for (int i = 0; i < 32; i++) step(1, 0, 0, 0, 6'(i), "R10");
        // R9: counts keep running while denied
        for (int i = 0; i < 8; i++) step(1, 0, 0, 0, 6'(i % 3), "R9");
        wr(6'd34, 32'd3, "R9");
        step(0, 0, 0, 0, 6'd0, "R9");
        step(0, 0, 0, 0, 6'd2, "R9");
        step(1, 0, 0, 0, 6'd17, "R9");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule